// File: doc/BRIEF.md
# Protected Configuration Byte and Program Store Readout

This block keeps an 8-bit configuration byte and a 4K-byte program store behind one access port. The configuration byte chooses the clock source, selects the data RAM size, and turns on a read guard for the program store. A programming station uses the port only while `prog_mode` is high. It can write and read the configuration byte, write and read program bytes, and start a full erase. The rest of the chip uses the decoded outputs: the clock selection, the RAM-size flag and the guard flag.

When the guard is on, every program-store read returns the fixed byte 0xE0 and every program-store write is dropped. The configuration byte still reads back its true value. An erase sweeps the whole store to 0xFF, one address per clock. At the start of the sweep the configuration byte returns to its blank value: 0x7F for the one-time variant (`ERASABLE`=0) or 0xFF for the erasable variant. Reset also loads the blank value.

A three-state controller sequences the block. State ST_RUN ignores the port and goes to ST_PROG when `prog_mode` is high. ST_PROG serves accesses, goes back to ST_RUN when `prog_mode` falls, and goes to ST_ERASE when `erase_req` is high (erase wins over an access in the same cycle). ST_ERASE writes one address per cycle and returns to ST_PROG after the last address.

Top module: `secure_cfg_store`

## Requirements
- R1: While reset is applied and at its release: the configuration byte equals the blank value (0x7F by default), `rd_valid`=0, `busy`=0, `clk_code_err`=0, `clk_src_sel`=2'b11 and `rd_data`=0.
- R2: When the controller is not in ST_PROG, port accesses have no effect. No `rd_valid` is produced and nothing is written. The controller reaches ST_PROG one cycle after `prog_mode` rises.
- R3: In ST_PROG, a configuration write (`acc_sel_cfg`=1, `acc_wr`=1) stores `acc_wdata`. A configuration read sets `rd_valid` and the stored byte on `rd_data` one clock after the request.
- R4: Bit 5 of the configuration byte is the guard bit and is active low: `protect_on` = 1 exactly when bit 5 is 0.
- R5: With the guard off, a program-store read of address A returns the byte last written to A, one clock after the request.
- R6: With the guard on, a program-store read of any address returns 0xE0.
- R7: With the guard on, program-store writes are dropped. The location keeps its old value, which a read shows after the guard is turned off.
- R8: The configuration byte reads back its true value while the guard is on.
- R9: Bits 4:3 select the clock: 2'b00 crystal, 2'b10 RC, 2'b11 external. `clk_src_sel` carries the same code and follows a configuration change one clock after the byte is stored.
- R10: Code 2'b01 is illegal. It sets `clk_code_err`, which stays set until reset, and `clk_src_sel` keeps its last legal code.
- R11: `ram_large` equals bit 1 of the configuration byte (1 selects 128 bytes, 0 selects 64 bytes).
- R12: `erase_req` in ST_PROG holds `busy` high for exactly 4096 cycles. During the sweep the port is ignored. Afterwards every program byte reads 0xFF and the configuration byte holds the blank value, so the guard is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_mode | input | 1 | Programming mode request |
| erase_req | input | 1 | Start a full erase (ST_PROG only) |
| acc_en | input | 1 | Port access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel_cfg | input | 1 | 1 = configuration byte, 0 = program store |
| acc_addr | input | 12 | Program store address |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid (one clock after request) |
| rd_data | output | 8 | Read data, 0 when not valid |
| busy | output | 1 | Erase sweep in progress |
| clk_src_sel | output | 2 | Decoded clock source code |
| ram_large | output | 1 | 128-byte RAM selected |
| protect_on | output | 1 | Read guard active |
| clk_code_err | output | 1 | Sticky illegal clock code flag |

## Verification
The assertions check on every cycle that a guarded program-store read produces 0xE0, that no read completes outside ST_PROG, that an erase starts with the blank configuration byte, and that the clock selection never shows the illegal code and holds while the field is illegal. They also check that the error flag stays set. Only the bench scenarios can show that stored data survives a dropped write under the guard, that the erase sweep lasts 4096 cycles and leaves 0xFF everywhere, and that accesses made in run mode leave no trace.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;

    typedef enum logic [1:0] {
        CLK_XTAL    = 2'b00,
        CLK_ILLEGAL = 2'b01,
        CLK_RC      = 2'b10,
        CLK_EXT     = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_PROG  = 2'b01,
        ST_ERASE = 2'b10
    } ctl_state_e;

    localparam int GUARD_BIT   = 5;
    localparam int CLK_HI_BIT  = 4;
    localparam int CLK_LO_BIT  = 3;
    localparam int RAMSZ_BIT   = 1;

endpackage

// File: rtl/cfgsec_ctl.sv
module cfgsec_ctl
    import cfgsec_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              erase_req,
    input  logic              acc_en,
    output ctl_state_e        state_o,
    output logic              acc_fire,
    output logic              erase_start,
    output logic              erase_we,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              busy
);

    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] sweep_q;
    logic              sweep_last;

    assign sweep_last = &sweep_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (prog_mode) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (erase_req)       state_d = ST_ERASE;
                else if (!prog_mode) state_d = ST_RUN;
            end
            ST_ERASE: begin
                if (sweep_last) state_d = ST_PROG;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ERASE) sweep_q <= sweep_q + 1'b1;
            else                     sweep_q <= '0;
        end
    end

    always_comb begin
        acc_fire    = 1'b0;
        erase_start = 1'b0;
        erase_we    = 1'b0;
        busy        = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_PROG: begin
                erase_start = erase_req;
                acc_fire    = acc_en && !erase_req;
            end
            ST_ERASE: begin
                erase_we = 1'b1;
                busy     = 1'b1;
            end
            default: ;
        endcase
    end

    assign erase_addr = sweep_q;
    assign state_o    = state_q;

    AST_NO_FIRE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !acc_fire) else $error("access during sweep"); // R12

    AST_SWEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> (busy && sweep_q == '0)) else $error("sweep entry"); // R12

endmodule

// File: rtl/cfgsec_cfgreg.sv
module cfgsec_cfgreg
    import cfgsec_pkg::*;
#(
    parameter int  DATA_W    = 8,
    parameter bit  ERASABLE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              load_blank,
    output logic [DATA_W-1:0] cfg_q,
    output logic              protect_on,
    output logic              ram_large,
    output clk_src_e          clk_src_sel,
    output logic              clk_code_err
);

    logic [DATA_W-1:0] blank_val;
    logic [1:0]        clk_field;
    clk_src_e          clk_q;
    logic              err_q;

    generate
        if (ERASABLE) begin : g_uv_blank
            assign blank_val = {DATA_W{1'b1}};
        end else begin : g_otp_blank
            assign blank_val = {1'b0, {(DATA_W-1){1'b1}}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= blank_val;
        else if (load_blank) cfg_q <= blank_val;
        else if (cfg_we)     cfg_q <= cfg_wdata;
    end

    assign clk_field = cfg_q[CLK_HI_BIT:CLK_LO_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= CLK_EXT;
            err_q <= 1'b0;
        end else if (clk_field == CLK_ILLEGAL) begin
            err_q <= 1'b1;
        end else begin
            clk_q <= clk_src_e'(clk_field);
        end
    end

    assign protect_on   = ~cfg_q[GUARD_BIT];
    assign ram_large    = cfg_q[RAMSZ_BIT];
    assign clk_src_sel  = clk_q;
    assign clk_code_err = err_q;

    AST_CLK_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_src_sel != CLK_ILLEGAL) else $error("illegal clk out"); // R10

    AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_field == CLK_ILLEGAL) |=> $stable(clk_src_sel)) else $error("clk not held"); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clk_code_err |=> clk_code_err) else $error("err cleared"); // R10

    AST_CLK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_field != CLK_ILLEGAL) |=> (clk_src_sel == $past(clk_field))) else $error("clk follow"); // R9

endmodule

// File: rtl/cfgsec_store.sv
module cfgsec_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        if (re) rd_q <= cells[raddr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/secure_cfg_store.sv
module secure_cfg_store
    import cfgsec_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 8,
    parameter bit          ERASABLE  = 1'b0,
    parameter logic [7:0]  MASK_BYTE = 8'hE0,
    parameter logic [7:0]  MEM_BLANK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              erase_req,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_sel_cfg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [1:0]        clk_src_sel,
    output logic              ram_large,
    output logic              protect_on,
    output logic              clk_code_err
);

    ctl_state_e        state;
    logic              acc_fire, erase_start, erase_we;
    logic [ADDR_W-1:0] erase_addr;
    logic [DATA_W-1:0] cfg_q;
    clk_src_e          clk_sel_e;

    logic              mem_we, mem_re, cfg_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic              rvalid_q, rcfg_q, rmask_q;
    logic [DATA_W-1:0] cfg_snap_q;

    cfgsec_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_mode   (prog_mode),
        .erase_req   (erase_req),
        .acc_en      (acc_en),
        .state_o     (state),
        .acc_fire    (acc_fire),
        .erase_start (erase_start),
        .erase_we    (erase_we),
        .erase_addr  (erase_addr),
        .busy        (busy)
    );

    assign cfg_we = acc_fire && acc_wr && acc_sel_cfg;

    cfgsec_cfgreg #(.DATA_W(DATA_W), .ERASABLE(ERASABLE)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (acc_wdata),
        .load_blank   (erase_start),
        .cfg_q        (cfg_q),
        .protect_on   (protect_on),
        .ram_large    (ram_large),
        .clk_src_sel  (clk_sel_e),
        .clk_code_err (clk_code_err)
    );

    assign clk_src_sel = clk_sel_e;

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = acc_addr;
        mem_wdata = acc_wdata;
        if (erase_we) begin
            mem_we    = 1'b1;
            mem_waddr = erase_addr;
            mem_wdata = MEM_BLANK[DATA_W-1:0];
        end else if (acc_fire && acc_wr && !acc_sel_cfg && !protect_on) begin
            mem_we = 1'b1;
        end
    end

    assign mem_re = acc_fire && !acc_wr && !acc_sel_cfg;

    cfgsec_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (acc_addr),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q   <= 1'b0;
            rcfg_q     <= 1'b0;
            rmask_q    <= 1'b0;
            cfg_snap_q <= '0;
        end else begin
            rvalid_q <= acc_fire && !acc_wr;
            if (acc_fire && !acc_wr) begin
                rcfg_q     <= acc_sel_cfg;
                rmask_q    <= protect_on;
                cfg_snap_q <= cfg_q;
            end
        end
    end

    always_comb begin
        if (!rvalid_q)    rd_data = '0;
        else if (rcfg_q)  rd_data = cfg_snap_q;
        else if (rmask_q) rd_data = MASK_BYTE[DATA_W-1:0];
        else              rd_data = mem_rdata;
    end

    assign rd_valid = rvalid_q;

    AST_GUARDED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !acc_wr && !acc_sel_cfg && protect_on) |=>
        (rd_valid && rd_data == MASK_BYTE[DATA_W-1:0])) else $error("unmasked read"); // R6

    AST_RUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PROG) |=> !rd_valid) else $error("read outside prog"); // R2

    AST_ERASE_BLANKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !protect_on) else $error("guard after erase"); // R12

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !acc_wr && acc_sel_cfg) |=> (rd_data == $past(cfg_q))) else $error("cfg readback"); // R8

endmodule

// File: tb/tb_secure_cfg_store.sv
module tb_secure_cfg_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b0;
    logic        erase_req = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_sel_cfg = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        busy;
    logic [1:0]  clk_src_sel;
    logic        ram_large;
    logic        protect_on;
    logic        clk_code_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    secure_cfg_store dut (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .erase_req(erase_req),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel_cfg(acc_sel_cfg),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .clk_src_sel(clk_src_sel),
        .ram_large(ram_large), .protect_on(protect_on), .clk_code_err(clk_code_err)
    );

    // vector: {cfg, wr, addr[11:0], wdata[7:0], is_read_check, expected[7:0]}
    localparam int NVEC = 15;
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 12'h000, 8'h3C, 1'b0, 8'h00},  // R5 write
        {1'b0, 1'b1, 12'hFFF, 8'hA5, 1'b0, 8'h00},  // R5 write top
        {1'b0, 1'b1, 12'h123, 8'h00, 1'b0, 8'h00},  // R5 write zero
        {1'b0, 1'b0, 12'h000, 8'h00, 1'b1, 8'h3C},  // R5
        {1'b0, 1'b0, 12'hFFF, 8'h00, 1'b1, 8'hA5},  // R5
        {1'b0, 1'b0, 12'h123, 8'h00, 1'b1, 8'h00},  // R5
        {1'b1, 1'b0, 12'h000, 8'h00, 1'b1, 8'h7F},  // R3
        {1'b1, 1'b1, 12'h000, 8'h5A, 1'b0, 8'h00},  // R3 guard on
        {1'b1, 1'b0, 12'h000, 8'h00, 1'b1, 8'h5A},  // R8
        {1'b0, 1'b0, 12'h000, 8'h00, 1'b1, 8'hE0},  // R6
        {1'b0, 1'b0, 12'hFFF, 8'h00, 1'b1, 8'hE0},  // R6
        {1'b0, 1'b1, 12'h000, 8'h11, 1'b0, 8'h00},  // R7 dropped write
        {1'b1, 1'b1, 12'h000, 8'h22, 1'b0, 8'h00},  // guard off
        {1'b0, 1'b0, 12'h000, 8'h00, 1'b1, 8'h3C},  // R7
        {1'b1, 1'b0, 12'h000, 8'h00, 1'b1, 8'h22}   // R3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic access(input bit sel, input bit wr, input logic [11:0] a, input logic [7:0] d);
        acc_en = 1'b1; acc_sel_cfg = sel; acc_wr = wr; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic cfg_read_expect(input logic [7:0] e, input string req);
        access(1'b1, 1'b0, 12'h0, 8'h0);
        chk(rd_valid && rd_data == e, req, rd_data, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_valid == 1'b0 && busy == 1'b0 && rd_data == 8'h00, "R1", {rd_valid, busy, rd_data}, 0);
        chk(clk_src_sel == 2'b11 && clk_code_err == 1'b0, "R1", {clk_src_sel, clk_code_err}, 6);
        chk(protect_on == 1'b0 && ram_large == 1'b1, "R1", {protect_on, ram_large}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        prog_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][30], VEC[i][29], VEC[i][28:17], VEC[i][16:9]);
            if (VEC[i][8]) chk(rd_valid && rd_data == VEC[i][7:0], "R5/R6/R7/R3/R8 vector",
                               rd_data, VEC[i][7:0]);
        end

        // cfg now 0x22: guard off, crystal, ram large
        @(negedge clk);
        chk(protect_on == 1'b0, "R4", protect_on, 0);
        chk(clk_src_sel == 2'b00, "R9", clk_src_sel, 0);
        chk(ram_large == 1'b1, "R11", ram_large, 1);

        // RC code 10, guard on (bit5=0), ram small: 0x10
        access(1'b1, 1'b1, 12'h0, 8'h10);
        chk(protect_on == 1'b1 && ram_large == 1'b0, "R4 R11", {protect_on, ram_large}, 2);
        @(negedge clk);
        chk(clk_src_sel == 2'b10, "R9", clk_src_sel, 2);

        // illegal code 01: 0x28
        access(1'b1, 1'b1, 12'h0, 8'h28);
        @(negedge clk);
        chk(clk_code_err == 1'b1 && clk_src_sel == 2'b10, "R10", {clk_code_err, clk_src_sel}, 6);
        access(1'b1, 1'b1, 12'h0, 8'h38);  // external, legal
        @(negedge clk);
        chk(clk_code_err == 1'b1 && clk_src_sel == 2'b11, "R10", {clk_code_err, clk_src_sel}, 7);

        // R2 run mode ignores the port
        prog_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        access(1'b1, 1'b1, 12'h0, 8'h00);
        chk(rd_valid == 1'b0 && clk_src_sel == 2'b11, "R2", {rd_valid, clk_src_sel}, 3);
        access(1'b1, 1'b0, 12'h0, 8'h00);
        chk(rd_valid == 1'b0, "R2", rd_valid, 0);
        prog_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cfg_read_expect(8'h38, "R2");

        // R12 erase with guard on
        access(1'b1, 1'b1, 12'h0, 8'h18);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        begin
            int n = 0;
            while (busy && n < 5000) begin
                if (n == 10) begin
                    acc_en = 1'b1; acc_sel_cfg = 1'b1; acc_wr = 1'b0;
                end else begin
                    acc_en = 1'b0;
                end
                @(negedge clk);
                if (n == 10) chk(rd_valid == 1'b0, "R12 port ignored", rd_valid, 0);
                n++;
            end
            acc_en = 1'b0;
            chk(n == 4096, "R12 sweep length", n, 4096);
        end
        chk(protect_on == 1'b0, "R12", protect_on, 0);
        cfg_read_expect(8'h7F, "R12");
        access(1'b0, 1'b0, 12'h000, 8'h0);
        chk(rd_valid && rd_data == 8'hFF, "R12", rd_data, 8'hFF);
        access(1'b0, 1'b0, 12'hFFF, 8'h0);
        chk(rd_valid && rd_data == 8'hFF, "R12", rd_data, 8'hFF);
        access(1'b0, 1'b0, 12'h123, 8'h0);
        chk(rd_valid && rd_data == 8'hFF, "R12", rd_data, 8'hFF);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule